// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block is an I2C target that behaves like a small serial EEPROM holding 2048 bytes in an internal register array. It watches the bus clock and data lines through a two-flop synchronizer. It detects START and STOP conditions, shifts bytes in and out most significant bit first, and pulls the data line low to acknowledge. The data line is open-drain: the block never drives it high. It only asserts an output enable that pulls the wire low.

After a START, the controller sends a select byte. That byte carries a fixed device code, three block bits and a direction bit. In a write transfer, a byte address follows the select byte, and then the data bytes. A mode input chooses between two write behaviours, and it is captured when the select byte is taken:

- **Multibyte mode:** a burst of up to eight bytes that advances the full address.
- **Page mode:** a burst of up to sixteen bytes that stays inside one sixteen-byte row.

A single data byte followed by STOP writes in either mode. In a read transfer, the block returns bytes from its current address for as long as the controller acknowledges them.

Top module: `eep_i2c_slave`

## Requirements
- R1: A select byte is accepted only when its bits 7:4 equal 1010. Bits 3:1 hold the block number and bit 0 holds the direction (1 = read, 0 = write). A select byte with any other code gets no acknowledge, and every later byte is ignored until the next START.
- R2: In a write transfer, the byte after the select byte is the byte address and is acknowledged. The memory address is {block bits, byte address}, which is 11 bits wide.
- R3: One data byte followed by STOP is stored at the addressed location, whether the mode input is high or low.
- R4: With the mode input high, up to 8 data bytes are acknowledged and stored at consecutive 11-bit addresses. The carry passes from the byte address into the block bits. Every further data byte in the same transfer gets no acknowledge and is not stored.
- R5: With the mode input low, up to 16 data bytes are acknowledged and stored, and only address bits 3:0 advance. The address therefore wraps to the start of the same row. Every further data byte gets no acknowledge and is not stored.
- R6: A read returns data from the current address, most significant bit first, and advances the full 11-bit address after each byte, wrapping from 0x7FF to 0x000. A select byte with the read bit set reloads address bits 10:8 from its block bits. A read without a preceding address byte continues from where the last transfer stopped. A controller NACK ends the read.
- R7: A START seen in the middle of a transfer (repeated START) restarts select-byte decoding and keeps the current address. This allows a random read: a write select byte, then the address byte, then a repeated START, then a read select byte.
- R8: A STOP returns the block to idle at any point. Bytes clocked in after a STOP without a new START get no acknowledge and change no memory content.
- R9: The block changes its data-line drive only while the bus clock is low, and never pulls the line low while the controller is sending a data or address bit. It pulls the line low during the 9th clock to acknowledge.
- R10: After reset, the data line is released and the current address is 0.
- R11: The mode input is sampled once, when a select byte is accepted. Changing it later in the same transfer does not change how the address advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, which oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| mode_i | input | 1 | Write behaviour select: 1 = multibyte, 0 = page |
| sda_oe | output | 1 | When 1, the data line is pulled low |

## Verification
The bench builds the block with its default parameters:

- three block bits, giving the full 2 KB array;
- four row bits;
- an 8-byte multibyte limit;
- a 16-byte page limit.

With these values a multibyte burst can cross a block boundary, and a sequential read can wrap from 0x7FF to 0x000. Bursts of 10 and 18 bytes push past both write limits. Page writes that start near the top of a row show the wrap inside that row.

// File: rtl/eep_pkg.sv
package eep_pkg;

    // Width of every byte on the bus and in the store.
    localparam int BYTE_W = 8;

    // Fixed device code carried in bits 7:4 of the select byte.
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVSEL,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA
    } phase_e;

    // How the address counter moves after a byte.
    typedef enum logic [1:0] {
        ADV_HOLD,
        ADV_FULL,
        ADV_ROW
    } adv_e;

    // Bus line levels and events after synchronization.
    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic dev_hit(input logic [BYTE_W-1:0] sel);
        return sel[BYTE_W-1 -: 4] == DEV_CODE;
    endfunction

endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync
    import eep_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic              scl_d, sda_d;
    logic              scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_d  <= scl_s;
            sda_d  <= sda_s;
        end
    end

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    always_comb begin
        ev.scl   = scl_s;
        ev.sda   = sda_s;
        ev.rise  = scl_s & ~scl_d;
        ev.fall  = ~scl_s & scl_d;
        ev.start = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/eep_addr_ctr.sv
module eep_addr_ctr
    import eep_pkg::*;
#(
    parameter int BLK_W = 3,
    parameter int LOW_W = 8,
    parameter int ROW_W = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ld_blk,
    input  logic [BLK_W-1:0]       blk_val,
    input  logic                   ld_low,
    input  logic [LOW_W-1:0]       low_val,
    input  adv_e                   adv,
    output logic [BLK_W+LOW_W-1:0] addr
);
    localparam int ADDR_W = BLK_W + LOW_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (ld_blk || ld_low) begin
            if (ld_blk) addr[ADDR_W-1 -: BLK_W] <= blk_val;
            if (ld_low) addr[LOW_W-1:0]         <= low_val;
        end else begin
            case (adv)
                ADV_FULL: addr <= addr + 1'b1;
                ADV_ROW:  addr[ROW_W-1:0] <= addr[ROW_W-1:0] + 1'b1;
                default:  ;
            endcase
        end
    end

    // R5
    row_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (adv == ADV_ROW && !ld_blk && !ld_low)
        |=> addr[ADDR_W-1:ROW_W] == $past(addr[ADDR_W-1:ROW_W]));

    // R6
    full_step_chk: assert property (@(posedge clk) disable iff (rst)
        (adv == ADV_FULL && !ld_blk && !ld_low)
        |=> addr == ADDR_W'($past(addr) + 1'b1));

endmodule

// File: rtl/eep_store.sv
module eep_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave
    import eep_pkg::*;
#(
    parameter int BLK_W     = 3,
    parameter int ROW_W     = 4,
    parameter int MULTI_MAX = 8,
    parameter int PAGE_MAX  = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic mode_i,
    output logic sda_oe
);
    localparam int ADDR_W = BLK_W + BYTE_W;
    localparam int CAP    = (PAGE_MAX > MULTI_MAX) ? PAGE_MAX : MULTI_MAX;
    localparam int CNT_W  = $clog2(CAP + 1);

    bus_ev_t           ev;
    phase_e            phase;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg, rx_byte, rdata;
    logic              ack_pend, rw_rd, page_mode, rd_nack;
    logic [CNT_W-1:0]  data_cnt, limit;
    logic [ADDR_W-1:0] addr;
    logic              byte_done, ld_blk, ld_low, accept, rd_sent;
    adv_e              adv;

    eep_line_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    eep_addr_ctr #(.BLK_W(BLK_W), .LOW_W(BYTE_W), .ROW_W(ROW_W)) u_addr (
        .clk     (clk),
        .rst     (rst),
        .ld_blk  (ld_blk),
        .blk_val (rx_byte[BLK_W:1]),
        .ld_low  (ld_low),
        .low_val (rx_byte),
        .adv     (adv),
        .addr    (addr)
    );

    eep_store #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_store (
        .clk   (clk),
        .we    (accept),
        .addr  (addr),
        .wdata (rx_byte),
        .rdata (rdata)
    );

    // Byte-level decode and address-counter control.
    always_comb begin
        rx_byte   = {shreg[BYTE_W-2:0], ev.sda};
        limit     = page_mode ? CNT_W'(PAGE_MAX) : CNT_W'(MULTI_MAX);
        byte_done = ev.rise && (bit_cnt == 4'd7) &&
                    (phase inside {ST_DEVSEL, ST_ADDR, ST_WDATA});
        ld_blk    = byte_done && (phase == ST_DEVSEL) && dev_hit(rx_byte);
        ld_low    = byte_done && (phase == ST_ADDR);
        accept    = byte_done && (phase == ST_WDATA) && (data_cnt < limit);
        rd_sent   = ev.fall && (phase == ST_RDATA) && (bit_cnt == 4'd8);
        if (accept)       adv = page_mode ? ADV_ROW : ADV_FULL;
        else if (rd_sent) adv = ADV_FULL;
        else              adv = ADV_HOLD;
    end

    // Bit engine and transfer phases.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= ST_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            sda_oe    <= 1'b0;
            ack_pend  <= 1'b0;
            rw_rd     <= 1'b0;
            page_mode <= 1'b0;
            rd_nack   <= 1'b0;
            data_cnt  <= '0;
        end else if (ev.stop) begin
            phase    <= ST_IDLE;
            bit_cnt  <= '0;
            sda_oe   <= 1'b0;
            ack_pend <= 1'b0;
        end else if (ev.start) begin
            phase    <= ST_DEVSEL;
            bit_cnt  <= '0;
            sda_oe   <= 1'b0;
            ack_pend <= 1'b0;
        end else if (phase != ST_IDLE) begin
            if (ev.rise) begin
                if (bit_cnt < 4'd8) begin
                    bit_cnt <= bit_cnt + 4'd1;
                    if (phase != ST_RDATA) shreg <= rx_byte;
                end else if (bit_cnt == 4'd8) begin
                    bit_cnt <= 4'd9;
                    rd_nack <= ev.sda;
                end
                if (byte_done) begin
                    case (phase)
                        ST_DEVSEL: begin
                            if (dev_hit(rx_byte)) begin
                                ack_pend  <= 1'b1;
                                rw_rd     <= rx_byte[0];
                                page_mode <= ~mode_i;
                                data_cnt  <= '0;
                            end else begin
                                ack_pend <= 1'b0;
                                phase    <= ST_IDLE;
                            end
                        end
                        ST_ADDR: ack_pend <= 1'b1;
                        ST_WDATA: begin
                            ack_pend <= accept;
                            if (accept) data_cnt <= data_cnt + 1'b1;
                        end
                        default: ack_pend <= 1'b0;
                    endcase
                end
            end else if (ev.fall) begin
                if (bit_cnt == 4'd8) begin
                    sda_oe <= (phase != ST_RDATA) && ack_pend;
                end else if (bit_cnt == 4'd9) begin
                    bit_cnt  <= '0;
                    sda_oe   <= 1'b0;
                    ack_pend <= 1'b0;
                    case (phase)
                        ST_DEVSEL: begin
                            if (rw_rd) begin
                                phase  <= ST_RDATA;
                                shreg  <= rdata;
                                sda_oe <= ~rdata[BYTE_W-1];
                            end else begin
                                phase <= ST_ADDR;
                            end
                        end
                        ST_ADDR: phase <= ST_WDATA;
                        ST_RDATA: begin
                            if (rd_nack) begin
                                phase <= ST_IDLE;
                            end else begin
                                shreg  <= rdata;
                                sda_oe <= ~rdata[BYTE_W-1];
                            end
                        end
                        default: ;
                    endcase
                end else if (phase == ST_RDATA && bit_cnt != 4'd0) begin
                    shreg  <= shreg << 1;
                    sda_oe <= ~shreg[BYTE_W-2];
                end
            end
        end
    end

    // R9
    oe_rise_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !ev.scl);

    // R1
    devsel_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_done && phase == ST_DEVSEL && !dev_hit(rx_byte))
        |=> (phase == ST_IDLE && !sda_oe));

    // R4
    wr_count_cap_chk: assert property (@(posedge clk) disable iff (rst)
        data_cnt <= limit);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_IDLE) |-> !sda_oe);

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (phase == ST_DEVSEL && bit_cnt == 4'd0));

endmodule

// File: tb/eep_i2c_slave_test.sv
`timescale 1ns/1ps
module eep_i2c_slave_test;

    localparam int T = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic mode_m = 1'b1;
    logic sda_oe;
    logic sda_line;

    int total = 0;
    int bad = 0;
    int drive_err = 0;
    bit done = 1'b0;

    logic [7:0] ref_mem [2048];
    bit         valid   [2048];

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    eep_i2c_slave uut (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_m),
        .sda_i  (sda_line),
        .mode_i (mode_m),
        .sda_oe (sda_oe)
    );

    typedef struct packed {
        logic       mode;
        logic [2:0] blk;
        logic [7:0] adr;
        logic [4:0] n;
        logic [7:0] seed;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd0, 8'h00, 5'd2,  8'h5A},  // R4 two bytes at 0x000
        '{1'b1, 3'd2, 8'h10, 5'd1,  8'h21},  // R3 byte write, mode high
        '{1'b0, 3'd2, 8'h20, 5'd1,  8'h37},  // R3 byte write, mode low
        '{1'b1, 3'd1, 8'hFC, 5'd8,  8'h80},  // R4 carry into block bits
        '{1'b1, 3'd0, 8'h48, 5'd2,  8'hC0},  // R4 preload 0x048..0x049
        '{1'b1, 3'd0, 8'h40, 5'd10, 8'h10},  // R4 9th and 10th refused
        '{1'b0, 3'd3, 8'h5C, 5'd8,  8'h90},  // R5 row wrap
        '{1'b0, 3'd4, 8'h70, 5'd18, 8'hA0},  // R5 17th and 18th refused
        '{1'b0, 3'd7, 8'hFE, 5'd3,  8'hE0}   // R5 wrap in top row
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hp();
        repeat (T) @(posedge clk);
        #1;
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; hp();
        scl_m = 1'b1; hp();
        sda_m = 1'b0; hp();
        scl_m = 1'b0; hp();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; hp();
        scl_m = 1'b1; hp();
        sda_m = 1'b1; hp();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hp();
            scl_m = 1'b1; hp();
            if (sda_line !== b[i]) drive_err++;
            scl_m = 1'b0; hp();
        end
        sda_m = 1'b1; hp();
        scl_m = 1'b1; hp();
        ack = (sda_line == 1'b0);
        scl_m = 1'b0; hp();
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        sda_m = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            hp();
            scl_m = 1'b1; hp();
            b = {b[6:0], sda_line};
            scl_m = 1'b0;
        end
        hp();
        sda_m = nack; hp();
        scl_m = 1'b1; hp();
        scl_m = 1'b0; hp();
        sda_m = 1'b1;
    endtask

    task automatic rd_at(input logic [10:0] a, output logic [7:0] d);
        logic k0, k1, k2;
        i2c_start();
        send_byte({4'hA, a[10:8], 1'b0}, k0);
        send_byte(a[7:0], k1);
        i2c_start();
        send_byte({4'hA, a[10:8], 1'b1}, k2);
        recv_byte(1'b1, d);
        i2c_stop();
        chk(k0 & k1 & k2, "R7 repeated START random read acks", {k0, k1, k2}, 3'b111);
    endtask

    function automatic logic [10:0] tgt(input vec_t v, input int i);
        logic [10:0] base;
        base = {v.blk, v.adr};
        if (v.mode) return base + 11'(i);
        return {v.blk, v.adr[7:4], 4'(v.adr[3:0] + 4'(i))};
    endfunction

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog all requirements actual=timeout expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic       k, ka, kb;
        logic [7:0] d, d0, d1, d2;
        int         lim;

        repeat (10) @(posedge clk);
        #1;
        chk(sda_oe == 1'b0, "R10 line released in reset", sda_oe, 0);
        rst = 1'b0;
        hp();
        chk(sda_oe == 1'b0, "R10 line released after reset", sda_oe, 0);

        // R1: wrong device codes are refused and the rest is ignored
        i2c_start();
        send_byte(8'h50, k);
        chk(!k, "R1 code 0101 refused", k, 0);
        send_byte(8'hA0, k);
        chk(!k, "R1 byte after refused select ignored", k, 0);
        i2c_stop();
        i2c_start();
        send_byte(8'hB0, k);
        chk(!k, "R1 code 1011 refused", k, 0);
        i2c_stop();

        // Vector table: write bursts, then read every target back
        foreach (VECS[vi]) begin
            vec_t v;
            v = VECS[vi];
            lim = (v.n == 5'd1) ? 1 : (v.mode ? 8 : 16);
            mode_m = v.mode;
            i2c_start();
            send_byte({4'hA, v.blk, 1'b0}, ka);
            send_byte(v.adr, kb);
            chk(ka & kb, "R2 select and address acked", {ka, kb}, 2'b11);
            for (int i = 0; i < int'(v.n); i++) begin
                send_byte(v.seed + 8'(i), k);
                chk(k == (i < lim), v.mode ? "R4 data ack" : "R5 data ack", k, (i < lim));
                if (i < lim) begin
                    ref_mem[tgt(v, i)] = v.seed + 8'(i);
                    valid[tgt(v, i)]   = 1'b1;
                end
            end
            i2c_stop();
            for (int i = 0; i < int'(v.n); i++) begin
                if (valid[tgt(v, i)]) begin
                    rd_at(tgt(v, i), d);
                    chk(d == ref_mem[tgt(v, i)],
                        (v.n == 5'd1) ? "R3 byte write readback" :
                        (v.mode ? "R4 multibyte readback" : "R5 page readback"),
                        d, ref_mem[tgt(v, i)]);
                end
            end
        end

        // R11: mode sampled at select byte; raising it later keeps page rules
        mode_m = 1'b0;
        i2c_start();
        send_byte({4'hA, 3'd5, 1'b0}, k);
        mode_m = 1'b1;
        send_byte(8'h6E, k);
        send_byte(8'h71, k);
        send_byte(8'h72, k);
        send_byte(8'h73, k);
        i2c_stop();
        ref_mem[11'h56E] = 8'h71;
        ref_mem[11'h56F] = 8'h72;
        ref_mem[11'h560] = 8'h73;
        rd_at(11'h560, d);
        chk(d == 8'h73, "R11 mode held at select, row wrap", d, 8'h73);
        rd_at(11'h56F, d);
        chk(d == 8'h72, "R11 mode held at select, second byte", d, 8'h72);

        // R6: sequential read wrapping 0x7FF -> 0x000, then current-address read
        i2c_start();
        send_byte({4'hA, 3'd7, 1'b0}, k);
        send_byte(8'hFE, k);
        i2c_start();
        send_byte({4'hA, 3'd7, 1'b1}, k);
        recv_byte(1'b0, d0);
        recv_byte(1'b0, d1);
        recv_byte(1'b1, d2);
        i2c_stop();
        chk(d0 == ref_mem[11'h7FE], "R6 sequential read byte 0", d0, ref_mem[11'h7FE]);
        chk(d1 == ref_mem[11'h7FF], "R6 sequential read byte 1", d1, ref_mem[11'h7FF]);
        chk(d2 == ref_mem[11'h000], "R6 sequential read wraps to 0x000", d2, ref_mem[11'h000]);
        i2c_start();
        send_byte({4'hA, 3'd0, 1'b1}, k);
        recv_byte(1'b1, d);
        i2c_stop();
        chk(d == ref_mem[11'h001], "R6 current address read", d, ref_mem[11'h001]);

        // R8: STOP mid-write, stray bytes after it are ignored
        mode_m = 1'b1;
        i2c_start();
        send_byte({4'hA, 3'd6, 1'b0}, k);
        send_byte(8'h31, k);
        send_byte(8'h11, k);
        i2c_stop();
        i2c_start();
        send_byte({4'hA, 3'd6, 1'b0}, k);
        send_byte(8'h30, k);
        send_byte(8'h3C, k);
        chk(k, "R8 data before STOP acked", k, 1);
        i2c_stop();
        send_byte(8'h99, k);
        chk(!k, "R8 byte after STOP not acked", k, 0);
        send_byte(8'h55, k);
        chk(!k, "R8 second byte after STOP not acked", k, 0);
        i2c_stop();
        rd_at(11'h630, d);
        chk(d == 8'h3C, "R8 byte before STOP kept", d, 8'h3C);
        rd_at(11'h631, d);
        chk(d == 8'h11, "R8 neighbour untouched by stray bytes", d, 8'h11);

        // R10: reset clears the address counter to 0
        @(posedge clk);
        rst = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        hp();
        i2c_start();
        send_byte({4'hA, 3'd0, 1'b1}, k);
        recv_byte(1'b1, d);
        i2c_stop();
        chk(d == ref_mem[11'h000], "R10 address 0 after reset", d, ref_mem[11'h000]);

        chk(drive_err == 0, "R9 no drive while controller sends bits", drive_err, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule